// File: doc/BRIEF.md
# Unified Storage Partition Allocator

This block divides one per-core storage pool of 393216 bytes among three uses: the register file, the software-managed scratchpad and the data cache. The pool is built from 32 banks, and all three uses share them. Software, or a launch sequencer, supplies the number of registers each thread needs and the number of scratchpad bytes each thread needs, then pulses start. The block picks the largest resident thread count whose register and scratchpad needs both fit in the pool. It reports that count, the size of each region, and where each region begins.

The register need comes first, so that the program never has to spill. The scratchpad need per thread is taken exactly as given. The cache is not a fixed size: it gets every byte left over once the other two regions are placed. Each region is rounded up to a whole stripe of 4096 bytes, which is 32 banks times 128 bytes. The regions are then packed in a fixed order: registers at offset 0, then the scratchpad, then the cache.

The search tries one thread count per clock cycle, starting at the largest. It latches its inputs when it starts, and a start that arrives during a search has no effect. The results stay the same between searches.

Top module: `ustor_alloc`

## Requirements
- R1: After reset, `done_o` and `err_o` are 0, and the thread count, the three sizes and the two base offsets are all 0.
- R2: The candidate thread counts are 1024, 768, 512 and 256, tried in that order. The result is the first one for which the rounded register region plus the rounded scratchpad region is at most 393216 bytes.
- R3: The register region size is threads × registers-per-thread × 4 bytes, rounded up to a multiple of 4096.
- R4: The scratchpad region size is threads × scratchpad-bytes-per-thread, rounded up to a multiple of 4096.
- R5: The cache size is 393216 minus the register region minus the scratchpad region. This may be 0.
- R6: The register region starts at offset 0. The scratchpad base equals the register region size. The cache base equals the register size plus the scratchpad size.
- R7: Start is sampled on a rising edge while no search is running. If candidate k fits (k = 0 for 1024, up to 3 for 256), then `done_o` is high for exactly one cycle after the (k+1)-th rising edge, counting the edge that sampled start as the first.
- R8: If no candidate fits, `done_o` pulses after the 4th edge. At the same time `err_o` is 1, and the thread count, the sizes and the bases are all 0.
- R9: While a search is running, the start input and changes to the need inputs have no effect on that search's result or on when it finishes.
- R10: The results and `err_o` change only in the cycle where `done_o` is high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a search (ignored while one is running) |
| regs_per_thread_i | input | 8 | Registers needed by each thread |
| spad_per_thread_i | input | 16 | Scratchpad bytes needed by each thread |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| err_o | output | 1 | No candidate thread count fits |
| threads_o | output | 11 | Chosen resident thread count |
| reg_bytes_o | output | 19 | Register region size in bytes |
| spad_bytes_o | output | 19 | Scratchpad region size in bytes |
| cache_bytes_o | output | 19 | Cache region size in bytes |
| spad_base_o | output | 19 | Byte offset where the scratchpad region starts |
| cache_base_o | output | 19 | Byte offset where the cache region starts |

## Verification
The sizes, the bases and `err_o` all become valid together in the single cycle where `done_o` pulses. That pulse comes one edge after start when 1024 threads fit, and one edge later for each larger candidate that is rejected. An error result arrives after four edges. The bench counts rising edges from the edge that samples start, reads `done_o` in the low phase of the clock, and requires the pulse in exactly the cycle predicted by the index of the expected candidate. It reads every result in that same cycle, and checks that `done_o` is low again one cycle later. For the ignore and hold cases, the bench keeps watching the results for several cycles after the stimulus and before the next start.

// File: rtl/ustor_pkg.sv
package ustor_pkg;

    // Width of the internal footprint arithmetic; covers 1024 threads x 64K bytes.
    localparam int unsigned CALC_W = 32;

    typedef logic [CALC_W-1:0] calc_t;

    // Round x up to the next multiple of 2**shift.
    function automatic calc_t ceil_to_stripe(input calc_t x, input int unsigned shift);
        calc_t mask;
        mask = (calc_t'(1) << shift) - calc_t'(1);
        return (x + mask) & ~mask;
    endfunction

endpackage

// File: rtl/ustor_footprint.sv
module ustor_footprint
    import ustor_pkg::*;
#(
    parameter int unsigned RPT_W      = 8,
    parameter int unsigned SPB_W      = 16,
    parameter int unsigned THR_W      = 11,
    parameter int unsigned REG_BYTES  = 4,
    parameter int unsigned GRAN_SHIFT = 12,
    parameter int unsigned POOL_BYTES = 393216
) (
    input  logic [THR_W-1:0] threads_i,
    input  logic [RPT_W-1:0] rpt_i,
    input  logic [SPB_W-1:0] spb_i,
    output calc_t            reg_region_o,
    output calc_t            spad_region_o,
    output logic             fits_o
);

    calc_t reg_raw;
    calc_t spad_raw;

    always_comb begin
        reg_raw       = calc_t'(threads_i) * calc_t'(rpt_i) * calc_t'(REG_BYTES);
        spad_raw      = calc_t'(threads_i) * calc_t'(spb_i);
        reg_region_o  = ceil_to_stripe(reg_raw, GRAN_SHIFT);
        spad_region_o = ceil_to_stripe(spad_raw, GRAN_SHIFT);
        fits_o        = (reg_region_o + spad_region_o) <= calc_t'(POOL_BYTES);
    end

endmodule

// File: rtl/ustor_layout.sv
module ustor_layout #(
    parameter int unsigned SZ_W       = 19,
    parameter int unsigned POOL_BYTES = 393216
) (
    input  logic [SZ_W-1:0] reg_sz_i,
    input  logic [SZ_W-1:0] spad_sz_i,
    output logic [SZ_W-1:0] spad_base_o,
    output logic [SZ_W-1:0] cache_base_o,
    output logic [SZ_W-1:0] cache_sz_o
);

    localparam logic [SZ_W-1:0] POOL_SZ = SZ_W'(POOL_BYTES);

    always_comb begin
        spad_base_o  = reg_sz_i;
        cache_base_o = reg_sz_i + spad_sz_i;
        cache_sz_o   = POOL_SZ - cache_base_o;
    end

endmodule

// File: rtl/ustor_alloc.sv
module ustor_alloc
    import ustor_pkg::*;
#(
    parameter int unsigned POOL_BYTES     = 393216,
    parameter int unsigned NUM_BANKS      = 32,
    parameter int unsigned BANK_ROW_BYTES = 128,
    parameter int unsigned REG_BYTES      = 4,
    parameter int unsigned MAX_THREADS    = 1024,
    parameter int unsigned THREAD_STEP    = 256,
    parameter int unsigned NUM_CAND       = 4,
    parameter int unsigned RPT_W          = 8,
    parameter int unsigned SPB_W          = 16,
    localparam int unsigned THR_W         = $clog2(MAX_THREADS + 1),
    localparam int unsigned SZ_W          = $clog2(POOL_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [RPT_W-1:0] regs_per_thread_i,
    input  logic [SPB_W-1:0] spad_per_thread_i,
    output logic             done_o,
    output logic             err_o,
    output logic [THR_W-1:0] threads_o,
    output logic [SZ_W-1:0]  reg_bytes_o,
    output logic [SZ_W-1:0]  spad_bytes_o,
    output logic [SZ_W-1:0]  cache_bytes_o,
    output logic [SZ_W-1:0]  spad_base_o,
    output logic [SZ_W-1:0]  cache_base_o
);

    localparam int unsigned GRAN_BYTES = NUM_BANKS * BANK_ROW_BYTES;
    localparam int unsigned GRAN_SHIFT = $clog2(GRAN_BYTES);
    localparam int unsigned IDX_W      = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CAND - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [RPT_W-1:0] rpt;
        logic [SPB_W-1:0] spb;
        logic             done;
        logic             err;
        logic [THR_W-1:0] threads;
        logic [SZ_W-1:0]  reg_sz;
        logic [SZ_W-1:0]  spad_sz;
        logic [SZ_W-1:0]  cache_sz;
        logic [SZ_W-1:0]  spad_base;
        logic [SZ_W-1:0]  cache_base;
    } state_t;

    state_t st_d;
    state_t st_q;

    // Candidate thread counts, largest first.
    logic [THR_W-1:0] cand_tbl [NUM_CAND];
    for (genvar g = 0; g < NUM_CAND; g++) begin : g_cand
        assign cand_tbl[g] = THR_W'(MAX_THREADS - g * THREAD_STEP);
    end

    logic             launch;
    logic [IDX_W-1:0] eval_idx;
    logic [RPT_W-1:0] eval_rpt;
    logic [SPB_W-1:0] eval_spb;
    logic [THR_W-1:0] eval_threads;
    calc_t            reg_region;
    calc_t            spad_region;
    logic             fits;
    logic [SZ_W-1:0]  lay_spad_base;
    logic [SZ_W-1:0]  lay_cache_base;
    logic [SZ_W-1:0]  lay_cache_sz;
    logic             busy_q;

    assign launch       = start_i && !st_q.busy;
    assign eval_idx     = st_q.busy ? st_q.idx : '0;
    assign eval_rpt     = st_q.busy ? st_q.rpt : regs_per_thread_i;
    assign eval_spb     = st_q.busy ? st_q.spb : spad_per_thread_i;
    assign eval_threads = cand_tbl[eval_idx];
    assign busy_q       = st_q.busy;

    ustor_footprint #(
        .RPT_W      (RPT_W),
        .SPB_W      (SPB_W),
        .THR_W      (THR_W),
        .REG_BYTES  (REG_BYTES),
        .GRAN_SHIFT (GRAN_SHIFT),
        .POOL_BYTES (POOL_BYTES)
    ) u_footprint (
        .threads_i     (eval_threads),
        .rpt_i         (eval_rpt),
        .spb_i         (eval_spb),
        .reg_region_o  (reg_region),
        .spad_region_o (spad_region),
        .fits_o        (fits)
    );

    ustor_layout #(
        .SZ_W       (SZ_W),
        .POOL_BYTES (POOL_BYTES)
    ) u_layout (
        .reg_sz_i     (reg_region[SZ_W-1:0]),
        .spad_sz_i    (spad_region[SZ_W-1:0]),
        .spad_base_o  (lay_spad_base),
        .cache_base_o (lay_cache_base),
        .cache_sz_o   (lay_cache_sz)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (launch) begin
            st_d.rpt = regs_per_thread_i;
            st_d.spb = spad_per_thread_i;
        end
        if (launch || st_q.busy) begin
            if (fits) begin
                st_d.busy       = 1'b0;
                st_d.done       = 1'b1;
                st_d.err        = 1'b0;
                st_d.threads    = eval_threads;
                st_d.reg_sz     = reg_region[SZ_W-1:0];
                st_d.spad_sz    = spad_region[SZ_W-1:0];
                st_d.cache_sz   = lay_cache_sz;
                st_d.spad_base  = lay_spad_base;
                st_d.cache_base = lay_cache_base;
            end else if (eval_idx == LAST_IDX) begin
                st_d.busy       = 1'b0;
                st_d.done       = 1'b1;
                st_d.err        = 1'b1;
                st_d.threads    = '0;
                st_d.reg_sz     = '0;
                st_d.spad_sz    = '0;
                st_d.cache_sz   = '0;
                st_d.spad_base  = '0;
                st_d.cache_base = '0;
            end else begin
                st_d.busy = 1'b1;
                st_d.idx  = eval_idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o        = st_q.done;
    assign err_o         = st_q.err;
    assign threads_o     = st_q.threads;
    assign reg_bytes_o   = st_q.reg_sz;
    assign spad_bytes_o  = st_q.spad_sz;
    assign cache_bytes_o = st_q.cache_sz;
    assign spad_base_o   = st_q.spad_base;
    assign cache_base_o  = st_q.cache_base;

endmodule

// File: rtl/ustor_alloc_checker.sv
module ustor_alloc_checker #(
    parameter int unsigned POOL_BYTES  = 393216,
    parameter int unsigned GRAN_BYTES  = 4096,
    parameter int unsigned THREAD_STEP = 256,
    parameter int unsigned MAX_THREADS = 1024,
    parameter int unsigned THR_W       = 11,
    parameter int unsigned SZ_W        = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_q,
    input logic             done_o,
    input logic             err_o,
    input logic [THR_W-1:0] threads_o,
    input logic [SZ_W-1:0]  reg_bytes_o,
    input logic [SZ_W-1:0]  spad_bytes_o,
    input logic [SZ_W-1:0]  cache_bytes_o,
    input logic [SZ_W-1:0]  spad_base_o,
    input logic [SZ_W-1:0]  cache_base_o
);

    assert_fit_in_pool_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> ((32'(reg_bytes_o) + 32'(spad_bytes_o)) <= POOL_BYTES)
            && (threads_o != '0) && ((32'(threads_o) % THREAD_STEP) == 0)
            && (32'(threads_o) <= MAX_THREADS));

    assert_reg_stripe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> ((32'(reg_bytes_o) % GRAN_BYTES) == 0));

    assert_spad_stripe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> ((32'(spad_bytes_o) % GRAN_BYTES) == 0));

    assert_cache_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> ((32'(reg_bytes_o) + 32'(spad_bytes_o) + 32'(cache_bytes_o)) == POOL_BYTES));

    assert_layout_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (spad_base_o == reg_bytes_o)
            && (32'(cache_base_o) == 32'(reg_bytes_o) + 32'(spad_bytes_o)));

    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i || busy_q));

    assert_error_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (threads_o == '0) && (reg_bytes_o == '0) && (spad_bytes_o == '0)
            && (cache_bytes_o == '0) && (spad_base_o == '0) && (cache_base_o == '0));

    assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(threads_o) && $stable(reg_bytes_o) && $stable(spad_bytes_o)
            && $stable(cache_bytes_o) && $stable(err_o) && $stable(cache_base_o));

endmodule

bind ustor_alloc ustor_alloc_checker #(
    .POOL_BYTES  (POOL_BYTES),
    .GRAN_BYTES  (NUM_BANKS * BANK_ROW_BYTES),
    .THREAD_STEP (THREAD_STEP),
    .MAX_THREADS (MAX_THREADS),
    .THR_W       (THR_W),
    .SZ_W        (SZ_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy_q        (busy_q),
    .done_o        (done_o),
    .err_o         (err_o),
    .threads_o     (threads_o),
    .reg_bytes_o   (reg_bytes_o),
    .spad_bytes_o  (spad_bytes_o),
    .cache_bytes_o (cache_bytes_o),
    .spad_base_o   (spad_base_o),
    .cache_base_o  (cache_base_o)
);

// File: tb/ustor_alloc_bench.sv
module ustor_alloc_bench;

    localparam longint POOL = 393216;
    localparam longint GRAN = 4096;
    localparam int NVEC = 10;
    localparam int VEC_RPT [NVEC] = '{32, 64, 96, 97, 128, 255, 255, 3, 0, 0};
    localparam int VEC_SPB [NVEC] = '{0, 64, 0, 0, 128, 100, 1000, 5, 384, 0};
    localparam int VEC_THR [NVEC] = '{1024, 1024, 1024, 768, 512, 256, 0, 1024, 1024, 1024};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  regs_per_thread_i = '0;
    logic [15:0] spad_per_thread_i = '0;
    logic        done_o, err_o;
    logic [10:0] threads_o;
    logic [18:0] reg_bytes_o, spad_bytes_o, cache_bytes_o, spad_base_o, cache_base_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ustor_alloc u_ustor_alloc (
        .clk               (clk),
        .rst_n             (rst_n),
        .start_i           (start_i),
        .regs_per_thread_i (regs_per_thread_i),
        .spad_per_thread_i (spad_per_thread_i),
        .done_o            (done_o),
        .err_o             (err_o),
        .threads_o         (threads_o),
        .reg_bytes_o       (reg_bytes_o),
        .spad_bytes_o      (spad_bytes_o),
        .cache_bytes_o     (cache_bytes_o),
        .spad_base_o       (spad_base_o),
        .cache_base_o      (cache_base_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ceil_g(input longint x);
        return ((x + GRAN - 1) / GRAN) * GRAN;
    endfunction

    // Independent model: returns chosen threads (0 on error), sizes, latency.
    task automatic model(input int rpt, input int spb, output longint thr, output longint rsz,
                         output longint ssz, output int lat);
        thr = 0; rsz = 0; ssz = 0; lat = 4;
        for (int k = 0; k < 4; k++) begin
            longint t;
            longint r;
            longint s;
            t = 1024 - 256 * k;
            r = ceil_g(t * rpt * 4);
            s = ceil_g(t * spb);
            if (r + s <= POOL) begin
                thr = t; rsz = r; ssz = s; lat = k + 1;
                break;
            end
        end
    endtask

    task automatic check_result(input int rpt, input int spb, input int lat_act);
        longint thr, rsz, ssz;
        int lat;
        model(rpt, spb, thr, rsz, ssz, lat);
        check(lat_act == lat, "R7 latency", lat_act, lat);
        check(longint'(threads_o) == thr, "R2 threads", threads_o, thr);
        check(err_o == (thr == 0), "R8 err", err_o, thr == 0);
        check(longint'(reg_bytes_o) == rsz, "R3 reg bytes", reg_bytes_o, rsz);
        check(longint'(spad_bytes_o) == ssz, "R4 spad bytes", spad_bytes_o, ssz);
        check(longint'(cache_bytes_o) == ((thr == 0) ? 0 : POOL - rsz - ssz), "R5 cache bytes",
              cache_bytes_o, (thr == 0) ? 0 : POOL - rsz - ssz);
        check(longint'(spad_base_o) == rsz, "R6 spad base", spad_base_o, rsz);
        check(longint'(cache_base_o) == rsz + ssz, "R6 cache base", cache_base_o, rsz + ssz);
    endtask

    // Pulse start at a negedge, then count edges until done is seen low-phase.
    task automatic launch(input int rpt, input int spb, output int lat);
        @(negedge clk);
        regs_per_thread_i = 8'(rpt);
        spad_per_thread_i = 16'(spb);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 10) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done_o && !err_o, "R1 flags", {done_o, err_o}, 0);
        check(threads_o == '0 && reg_bytes_o == '0 && spad_bytes_o == '0, "R1 sizes",
              threads_o + reg_bytes_o + spad_bytes_o, 0);
        check(cache_bytes_o == '0 && spad_base_o == '0 && cache_base_o == '0, "R1 bases",
              cache_bytes_o + spad_base_o + cache_base_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            longint thr, rsz, ssz;
            int mlat;
            model(VEC_RPT[v], VEC_SPB[v], thr, rsz, ssz, mlat);
            check(thr == VEC_THR[v], "R2 model table", thr, VEC_THR[v]);
            launch(VEC_RPT[v], VEC_SPB[v], lat);
            check_result(VEC_RPT[v], VEC_SPB[v], lat);
            @(negedge clk);
            check(!done_o, "R7 single pulse", done_o, 0);
        end

        // R9: start and input changes during a search are ignored
        @(negedge clk);
        regs_per_thread_i = 8'd255;
        spad_per_thread_i = 16'd100;
        start_i = 1'b1;
        @(negedge clk);
        regs_per_thread_i = 8'd32;
        spad_per_thread_i = 16'd0;
        lat = 1;
        @(negedge clk);
        start_i = 1'b0;
        lat++;
        while (!done_o && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        check(longint'(threads_o) == 256, "R9 ignored start threads", threads_o, 256);
        check_result(255, 100, lat);

        // R10: inputs change without start, results hold
        regs_per_thread_i = 8'd1;
        spad_per_thread_i = 16'd1;
        repeat (6) begin
            @(negedge clk);
            check(!done_o && threads_o == 11'd256, "R10 hold threads", threads_o, 256);
        end
        check(reg_bytes_o == 19'd262144 && spad_bytes_o == 19'd28672, "R10 hold sizes",
              reg_bytes_o, 262144);

        // R8 then success: error result clears on next good search
        launch(255, 1000, lat);
        check_result(255, 1000, lat);
        launch(96, 0, lat);
        check_result(96, 0, lat);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule